// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Front End

This block sits in front of a small processor core. It gathers five hardware interrupt requests and applies the trigger rule of each one, the per-source masks and a global enable flag. At each sample point it selects the most urgent eligible request. The core raises `sampleEn` for one cycle when the current instruction is about to finish, which is the only moment the block accepts a request.

Four sources have fixed vectors. When one of them is accepted, the block pulses `takeValid` and presents a 16-bit service address on `takeVector`. The fifth source is the external, non-vectored request. Accepting it starts an acknowledge handshake: `extAck` stays high until the peripheral supplies a restart opcode on `opcodeIn`, and that opcode is then turned into a vector.

Software controls the block through three things: a pair of strobes that set or clear the enable flag, a write port that takes an 8-bit mask word, and an 8-bit status byte that reports pending, enable and mask state.

Top module: `irqFront`

## Requirements
- R1: On a cycle with `sampleEn` high, the block accepts at most one eligible request. The fixed priority from highest to lowest is `nmiReq`, `edgeReq`, `lvlHiReq`, `lvlLoReq`, `extReq`. A vectored acceptance drives `takeValid` high for exactly the cycle after that clock edge.
- R2: The vectors are 0x0024 for `nmiReq`, 0x003C for `edgeReq`, 0x0034 for `lvlHiReq` and 0x002C for `lvlLoReq`.
- R3: `nmiReq` ignores the enable flag and the masks. It is accepted only if it rose since it was last low or last accepted, and it is still high at the sample point. A request that drops before the sample point is lost, and holding it high after it is accepted gives no second acceptance.
- R4: A rising edge on `edgeReq` sets a pending latch that stays set after the input falls, and also while the source is masked. The latch clears when the source is accepted, or on a mask write with bit 4 set. Status bit 6 shows the latch.
- R5: `lvlHiReq` and `lvlLoReq` are eligible only while they are high at the sample point. Status bits 5 and 4 show their live levels.
- R6: `enableSet` sets the enable flag and `enableClr` clears it; when both are high, the clear wins. Any acceptance clears the flag. While the flag is clear, only `nmiReq` can be accepted. Status bit 3 shows the flag.
- R7: A `maskWe` cycle with bit 3 of `maskWord` set loads the masks from bits 2, 1 and 0, for `edgeReq`, `lvlHiReq` and `lvlLoReq` respectively, where 1 means masked. With bit 3 clear, the masks keep their values. Status bits 2 to 0 show the masks, and status bit 7 reads 0.
- R8: Requests present on cycles without `sampleEn` are not accepted.
- R9: Accepting `extReq` raises `extAck` in the cycle after the sample edge, with no `takeValid`. While `extAck` is high, sample points accept nothing.
- R10: While `extAck` is high, an `opcodeValid` byte of the form 11nnn111b gives `takeValid` with vector n*8 in the next cycle and drops `extAck`. Any other byte is ignored: `extAck` stays high and there is no `takeValid`.
- R11: After reset the enable flag is clear, all three masks are set and all latches are clear. The status byte reads 0x07, and `extAck` and `takeValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nmiReq | input | 1 | Non-maskable request, edge-and-level |
| edgeReq | input | 1 | Edge-latched maskable request |
| lvlHiReq | input | 1 | Level maskable request, higher of the two |
| lvlLoReq | input | 1 | Level maskable request, lower of the two |
| extReq | input | 1 | Non-vectored level request |
| sampleEn | input | 1 | Sample point from the core |
| enableSet | input | 1 | Set the enable flag |
| enableClr | input | 1 | Clear the enable flag |
| maskWe | input | 1 | Mask word write strobe |
| maskWord | input | 8 | Mask word (bit 4 clears edge latch, bit 3 update enable, bits 2..0 masks) |
| opcodeValid | input | 1 | Opcode byte present during acknowledge |
| opcodeIn | input | 8 | Restart opcode from the peripheral |
| statusByte | output | 8 | Pending, enable and mask status |
| takeValid | output | 1 | One-cycle pulse: vector is valid |
| takeVector | output | 16 | Service address |
| extAck | output | 1 | Acknowledge to the external requester |

## Verification
The hardest situation to reach from the ports is a conflict between sources of different trigger kinds. The bench builds it up over several cycles with `sampleEn` held low. It first latches an edge pulse that has already dropped, next raises both level inputs, and only then opens a sample point. It then re-enables the block between successive sample points so that the sources drain one by one in priority order. The acknowledge handshake is held open with a malformed opcode and a further sample point, to show that both are ignored before a well-formed opcode closes it.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int NUM_SRC = 5;
  localparam int VEC_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int SLOT_W  = 3;
  localparam int SLOT_SH = 3;

  // Source index: larger index means higher priority.
  localparam int SRC_EXT  = 0;
  localparam int SRC_LO   = 1;
  localparam int SRC_HI   = 2;
  localparam int SRC_EDGE = 3;
  localparam int SRC_NMI  = 4;

  localparam logic [VEC_W-1:0] VEC_NMI  = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_EDGE = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_HI   = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_LO   = 16'h002C;

  typedef struct packed {
    logic [NUM_SRC-1:0] grant;
    logic               opTake;
    logic [SLOT_W-1:0]  opSlot;
  } ctrlStrobe_t;

  function automatic logic [VEC_W-1:0] slotVector(input logic [SLOT_W-1:0] slot);
    return {{(VEC_W-SLOT_W-SLOT_SH){1'b0}}, slot, {SLOT_SH{1'b0}}};
  endfunction
endpackage

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiReq,
  input  logic               edgeReq,
  input  logic               lvlHiReq,
  input  logic               lvlLoReq,
  input  logic               extReq,
  input  logic               enableSet,
  input  logic               enableClr,
  input  logic               maskWe,
  input  logic [BYTE_W-1:0]  maskWord,
  input  ctrlStrobe_t        strobe,
  output logic [NUM_SRC-1:0] ready,
  output logic [BYTE_W-1:0]  statusByte,
  output logic               takeValid,
  output logic [VEC_W-1:0]   takeVector
);
  localparam int MASK_N = 3;

  logic enFlag;
  logic [MASK_N-1:0] maskBits;   // [2] edge, [1] high level, [0] low level
  logic edgePrev, edgePend, nmiPrev, nmiArm;
  logic edgeRise, nmiRise, maskLoad, edgeClrCmd, anyGrant;
  logic unusedSerial;

  assign edgeRise     = edgeReq & ~edgePrev;
  assign nmiRise      = nmiReq & ~nmiPrev;
  assign maskLoad     = maskWe & maskWord[3];
  assign edgeClrCmd   = maskWe & maskWord[4];
  assign anyGrant     = |strobe.grant;
  assign unusedSerial = ^maskWord[BYTE_W-1:5];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgePrev <= 1'b0;
      nmiPrev  <= 1'b0;
    end else begin
      edgePrev <= edgeReq;
      nmiPrev  <= nmiReq;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                enFlag <= 1'b0;
    else if (anyGrant)        enFlag <= 1'b0;
    else if (enableClr)       enFlag <= 1'b0;
    else if (enableSet)       enFlag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         maskBits <= '1;
    else if (maskLoad) maskBits <= maskWord[MASK_N-1:0];
  end

  // A fresh edge wins over a clear in the same cycle, so no edge is lost.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        edgePend <= 1'b0;
    else if (edgeRise)                                edgePend <= 1'b1;
    else if (strobe.grant[SRC_EDGE] || edgeClrCmd)    edgePend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       nmiArm <= 1'b0;
    else if (strobe.grant[SRC_NMI])  nmiArm <= 1'b0;
    else if (!nmiReq)                nmiArm <= 1'b0;
    else if (nmiRise)                nmiArm <= 1'b1;
  end

  always_comb begin
    ready           = '0;
    ready[SRC_NMI]  = nmiArm & nmiReq;
    ready[SRC_EDGE] = edgePend & ~maskBits[2] & enFlag;
    ready[SRC_HI]   = lvlHiReq & ~maskBits[1] & enFlag;
    ready[SRC_LO]   = lvlLoReq & ~maskBits[0] & enFlag;
    ready[SRC_EXT]  = extReq & enFlag;
  end

  assign statusByte = {1'b0, edgePend, lvlHiReq, lvlLoReq, enFlag, maskBits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeValid  <= 1'b0;
      takeVector <= '0;
    end else begin
      takeValid <= (|strobe.grant[NUM_SRC-1:1]) | strobe.opTake;
      if (strobe.grant[SRC_NMI])       takeVector <= VEC_NMI;
      else if (strobe.grant[SRC_EDGE]) takeVector <= VEC_EDGE;
      else if (strobe.grant[SRC_HI])   takeVector <= VEC_HI;
      else if (strobe.grant[SRC_LO])   takeVector <= VEC_LO;
      else if (strobe.opTake)          takeVector <= slotVector(strobe.opSlot);
    end
  end

  assert_accept_clears_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    anyGrant |=> !enFlag);

  assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    maskLoad |=> (maskBits == $past(maskWord[MASK_N-1:0])));

  assert_edge_pend_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (edgePend && !strobe.grant[SRC_EDGE] && !edgeClrCmd) |=> edgePend);
endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] ready,
  input  logic               sampleEn,
  input  logic               opcodeValid,
  input  logic [BYTE_W-1:0]  opcodeIn,
  output ctrlStrobe_t        strobe,
  output logic               extAck
);
  typedef enum logic {ST_IDLE, ST_ACK} ackState_t;
  ackState_t state;

  logic [NUM_SRC-1:0] pick;
  logic opcodeOk;

  // Highest index that is ready wins.
  always_comb begin
    pick = '0;
    if (sampleEn && state == ST_IDLE) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (ready[i]) pick = NUM_SRC'(1) << i;
      end
    end
  end

  assign opcodeOk = (opcodeIn[7:6] == 2'b11) && (opcodeIn[2:0] == 3'b111);

  always_comb begin
    strobe.grant  = pick;
    strobe.opTake = (state == ST_ACK) && opcodeValid && opcodeOk;
    strobe.opSlot = opcodeIn[5:3];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else begin
      case (state)
        ST_IDLE: if (pick[SRC_EXT]) state <= ST_ACK;
        ST_ACK:  if (strobe.opTake) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign extAck = (state == ST_ACK);

  assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.grant));

  assert_ext_grant_acks_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grant[SRC_EXT] |=> extAck);

  assert_no_grant_in_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    extAck |-> (strobe.grant == '0));

  assert_bad_opcode_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (extAck && !strobe.opTake) |=> extAck);
endmodule

// File: rtl/irqFront.sv
module irqFront
  import irqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiReq,
  input  logic              edgeReq,
  input  logic              lvlHiReq,
  input  logic              lvlLoReq,
  input  logic              extReq,
  input  logic              sampleEn,
  input  logic              enableSet,
  input  logic              enableClr,
  input  logic              maskWe,
  input  logic [7:0]        maskWord,
  input  logic              opcodeValid,
  input  logic [7:0]        opcodeIn,
  output logic [7:0]        statusByte,
  output logic              takeValid,
  output logic [15:0]       takeVector,
  output logic              extAck
);
  ctrlStrobe_t strobe;
  logic [NUM_SRC-1:0] ready;

  irqDatapath i_datapath (
    .clk(clk), .rstN(rstN),
    .nmiReq(nmiReq), .edgeReq(edgeReq), .lvlHiReq(lvlHiReq),
    .lvlLoReq(lvlLoReq), .extReq(extReq),
    .enableSet(enableSet), .enableClr(enableClr),
    .maskWe(maskWe), .maskWord(maskWord),
    .strobe(strobe), .ready(ready), .statusByte(statusByte),
    .takeValid(takeValid), .takeVector(takeVector)
  );

  irqControl i_control (
    .clk(clk), .rstN(rstN), .ready(ready), .sampleEn(sampleEn),
    .opcodeValid(opcodeValid), .opcodeIn(opcodeIn),
    .strobe(strobe), .extAck(extAck)
  );
endmodule

// File: tb/test_irqFront.sv
module test_irqFront;
  logic clk = 1'b0, rstN = 1'b0;
  logic nmiReq = 0, edgeReq = 0, lvlHiReq = 0, lvlLoReq = 0, extReq = 0;
  logic sampleEn = 0, enableSet = 0, enableClr = 0, maskWe = 0, opcodeValid = 0;
  logic [7:0] maskWord = 0, opcodeIn = 0;
  logic [7:0] statusByte;
  logic takeValid, extAck;
  logic [15:0] takeVector;
  int runCount = 0, failCount = 0;
  logic gotTake, gotAck;
  logic [15:0] gotVec;

  always #2.5 clk = ~clk;

  irqFront i_irqFront (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doSample();
    @(negedge clk) sampleEn = 1;
    @(posedge clk); #1;
    gotTake = takeValid; gotVec = takeVector; gotAck = extAck;
    @(negedge clk) sampleEn = 0;
  endtask

  task automatic writeMask(input logic [7:0] v);
    @(negedge clk) begin maskWe = 1; maskWord = v; end
    @(negedge clk) maskWe = 0;
  endtask

  task automatic pulseSet();
    @(negedge clk) enableSet = 1;
    @(negedge clk) enableSet = 0;
  endtask

  task automatic pulseEdge();
    @(negedge clk) edgeReq = 1;
    @(negedge clk) edgeReq = 0;
  endtask

  task automatic testReset();
    check("R11 status", {8'h0, statusByte}, 16'h0007);
    check("R11 ack", {15'h0, extAck}, 16'h0);
    check("R11 take", {15'h0, takeValid}, 16'h0);
  endtask

  task automatic testEnableMask();
    writeMask(8'h08);
    check("R7 masks loaded", {8'h0, statusByte}, 16'h0000);
    writeMask(8'h07);
    check("R7 no update without bit3", {8'h0, statusByte}, 16'h0000);
    pulseSet();
    check("R6 set", {8'h0, statusByte}, 16'h0008);
    @(negedge clk) begin enableSet = 1; enableClr = 1; end
    @(negedge clk) begin enableSet = 0; enableClr = 0; end
    check("R6 clear wins", {8'h0, statusByte}, 16'h0000);
  endtask

  task automatic testPriority();
    pulseEdge();
    @(negedge clk) begin lvlHiReq = 1; lvlLoReq = 1; end
    @(negedge clk);
    check("R4 R5 status pending", {8'h0, statusByte}, 16'h0070);
    pulseSet();
    repeat (3) begin
      @(posedge clk); #1;
      check("R8 no take without sample", {15'h0, takeValid}, 16'h0);
    end
    doSample();
    check("R1 take", {15'h0, gotTake}, 16'h1);
    check("R2 edge vector", gotVec, 16'h003C);
    @(posedge clk); #1;
    check("R1 single pulse", {15'h0, takeValid}, 16'h0);
    check("R4 R6 latch and enable cleared", {8'h0, statusByte}, 16'h0030);
    doSample();
    check("R6 disabled blocks", {15'h0, gotTake}, 16'h0);
    pulseSet();
    doSample();
    check("R2 high level vector", gotVec, 16'h0034);
    @(negedge clk) lvlHiReq = 0;
    pulseSet();
    doSample();
    check("R5 low level take", {15'h0, gotTake}, 16'h1);
    check("R2 low level vector", gotVec, 16'h002C);
    @(negedge clk) lvlLoReq = 0;
    pulseSet();
    doSample();
    check("R5 level gone", {15'h0, gotTake}, 16'h0);
  endtask

  task automatic testMaskedEdge();
    writeMask(8'h0C);
    pulseEdge();
    doSample();
    check("R7 masked edge not taken", {15'h0, gotTake}, 16'h0);
    check("R4 pending while masked", {8'h0, statusByte}, 16'h004C);
    writeMask(8'h10);
    check("R4 clear by mask word", {8'h0, statusByte}, 16'h000C);
    writeMask(8'h08);
    doSample();
    check("R4 cleared latch gives nothing", {15'h0, gotTake}, 16'h0);
  endtask

  task automatic testNmi();
    @(negedge clk) enableClr = 1;
    @(negedge clk) enableClr = 0;
    writeMask(8'h0F);
    @(negedge clk) nmiReq = 1;
    doSample();
    check("R3 nmi take", {15'h0, gotTake}, 16'h1);
    check("R2 nmi vector", gotVec, 16'h0024);
    doSample();
    check("R3 held high no retake", {15'h0, gotTake}, 16'h0);
    @(negedge clk) nmiReq = 0;
    @(negedge clk) nmiReq = 1;
    @(negedge clk) nmiReq = 0;
    doSample();
    check("R3 dropped before sample", {15'h0, gotTake}, 16'h0);
    writeMask(8'h08);
    pulseSet();
    pulseEdge();
    @(negedge clk) nmiReq = 1;
    doSample();
    check("R1 nmi over edge", gotVec, 16'h0024);
    @(negedge clk) nmiReq = 0;
    pulseSet();
    doSample();
    check("R1 edge next", gotVec, 16'h003C);
  endtask

  task automatic testExt();
    pulseSet();
    @(negedge clk) extReq = 1;
    doSample();
    check("R9 ack raised", {15'h0, gotAck}, 16'h1);
    check("R9 no take", {15'h0, gotTake}, 16'h0);
    @(negedge clk) extReq = 0;
    pulseSet();
    @(negedge clk) lvlLoReq = 1;
    doSample();
    check("R9 sampling suspended", {15'h0, gotTake}, 16'h0);
    @(negedge clk) begin lvlLoReq = 0; opcodeValid = 1; opcodeIn = 8'hC6; end
    @(posedge clk); #1;
    check("R10 bad opcode no take", {15'h0, takeValid}, 16'h0);
    check("R10 bad opcode ack held", {15'h0, extAck}, 16'h1);
    @(negedge clk) opcodeIn = 8'hEF;
    @(posedge clk); #1;
    check("R10 opcode take", {15'h0, takeValid}, 16'h1);
    check("R10 slot vector", takeVector, 16'h0028);
    check("R10 ack dropped", {15'h0, extAck}, 16'h0);
    @(negedge clk) opcodeValid = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    failCount++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testEnableMask();
    testPriority();
    testMaskedEdge();
    testNmi();
    testExt();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule